// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two bidirectional ports, A and B, through a pair of storage registers and a source multiplexer per direction. The port pins are modelled as separate input, output and per-bit output-enable vectors, so the block sits behind ordinary tristate pads. The data width is split into independent slices of `SLICE_W` bits each. Every slice has its own active-low output enable, direction line, two source selects and two store strobes. Tying the controls of all slices together turns the block into one wide transceiver.

For each direction the driven port takes either the live value on the opposite port (real-time) or that port's stored copy (recall). A store strobe rising captures the current value of its own port into that port's register. This happens in every mode, including while both ports are isolated. Two supply-good inputs, one per side, force every slice off its pins when either supply is reported down. All state and all outputs are registered on one system clock. Store strobes are sampled on that clock and their rising edges are detected in the block.

Top module: `regbus_xcvr`

## Requirements
- R1: Each slice (bits `s*SLICE_W` upward) obeys only its own six control bits. Slices with different controls behave independently in the same cycle.
- R2: If a slice's `oe_n` is 1 in a cycle, all of that slice's `a_oe` and `b_oe` bits are 0 after the next clock edge.
- R3: With the slice enabled and both supplies good, `dir`=0 sets all of the slice's `a_oe` bits and `dir`=1 sets all of its `b_oe` bits after the next edge. A slice never has `a_oe` and `b_oe` bits set in the same cycle.
- R4: With the select of the active direction at 0, the driven port's `*_out` equals the opposite port's input from the previous cycle (`sel_ba` governs A, `sel_ab` governs B).
- R5: With that select at 1, the driven port's `*_out` equals the opposite side's storage register as it stood before the edge.
- R6: A store strobe seen at 0 in one clock cycle and at 1 in the next captures that side's port value into its register at that edge, whatever the output enable, direction and selects are. Both strobes may rise in the same cycle and both registers then load.
- R7: Without a rising store strobe, a register keeps its value for any number of cycles, including while isolated.
- R8: If `pwr_a_ok` or `pwr_b_ok` is 0 in a cycle, every `a_oe` and `b_oe` bit of every slice is 0 after the next edge, whatever `oe_n` and `dir` are.
- R9: When a select changes, the driven output goes from the old source's value to the new source's value in one clock, with no other value between them.
- R10: The value captured for a port is the value the block itself drives when its enable for that port is set, and the port input otherwise.
- R11: Synchronous reset `rst`=1 clears both registers and the strobe edge history of every slice, all `*_out` bits and all `*_oe` bits at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| oe_n | input | SLICES | Per-slice output enable, active low |
| dir | input | SLICES | Per-slice direction: 0 drives A, 1 drives B |
| sel_ab | input | SLICES | Source for B: 0 live A, 1 stored A |
| sel_ba | input | SLICES | Source for A: 0 live B, 1 stored B |
| stclk_a | input | SLICES | Store strobe for the A-side register |
| stclk_b | input | SLICES | Store strobe for the B-side register |
| pwr_a_ok | input | 1 | A-side supply good |
| pwr_b_ok | input | 1 | B-side supply good |
| a_in | input | SLICES*SLICE_W | A port pin input |
| a_out | output | SLICES*SLICE_W | A port pin output value |
| a_oe | output | SLICES*SLICE_W | A port per-bit output enable |
| b_in | input | SLICES*SLICE_W | B port pin input |
| b_out | output | SLICES*SLICE_W | B port pin output value |
| b_oe | output | SLICES*SLICE_W | B port per-bit output enable |

## Verification
The bench goes after captures made while isolated or while the block drives the port being stored. A design that stored the raw pin input there would later recall junk instead of its own driven value. It toggles selects against a changed live input, where a mux with a stale or mixed source would show a third value or a one-cycle lag. It drops each supply in turn, where a design that gated only on `oe_n` would keep driving. It flips direction every cycle and runs the two slices with opposite settings, where shared decode would make one slice follow the other or enable both ports at once.

// File: rtl/regbus_pkg.sv
package regbus_pkg;

  typedef struct packed {
    logic oe_n;
    logic dir;
    logic sel_ab;
    logic sel_ba;
    logic stclk_a;
    logic stclk_b;
  } slice_ctrl_t;

  typedef enum logic [1:0] {
    DRV_NONE = 2'b00,
    DRV_A    = 2'b01,
    DRV_B    = 2'b10
  } drive_t;

endpackage

// File: rtl/regbus_edge.sv
module regbus_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);

  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;

endmodule

// File: rtl/regbus_store.sv
module regbus_store #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_r;

  always_ff @(posedge clk) begin
    if (rst)       q_r <= '0;
    else if (load) q_r <= d;
  end

  assign q = q_r;

endmodule

// File: rtl/regbus_slice.sv
module regbus_slice
  import regbus_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  slice_ctrl_t  ctrl,
  input  logic         pwr_ok,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe
);

  logic [1:0]   rise;
  logic [W-1:0] res_a, res_b;
  logic [W-1:0] reg_a, reg_b;
  logic [W-1:0] nxt_a, nxt_b;
  logic [W-1:0] a_out_q, b_out_q;
  drive_t       drv_d, drv_q;

  regbus_edge #(.N(2)) edge_i (
    .clk  (clk),
    .rst  (rst),
    .lvl  ({ctrl.stclk_b, ctrl.stclk_a}),
    .rise (rise)
  );

  // Resolved pin value: own drive wins over the external input
  assign res_a = (drv_q == DRV_A) ? a_out_q : a_in;
  assign res_b = (drv_q == DRV_B) ? b_out_q : b_in;

  regbus_store #(.W(W)) store_a_i (
    .clk  (clk),
    .rst  (rst),
    .load (rise[0]),
    .d    (res_a),
    .q    (reg_a)
  );

  regbus_store #(.W(W)) store_b_i (
    .clk  (clk),
    .rst  (rst),
    .load (rise[1]),
    .d    (res_b),
    .q    (reg_b)
  );

  always_comb begin
    nxt_a = ctrl.sel_ba ? reg_b : b_in;
    nxt_b = ctrl.sel_ab ? reg_a : a_in;
    if (ctrl.oe_n || !pwr_ok) drv_d = DRV_NONE;
    else if (ctrl.dir)        drv_d = DRV_B;
    else                      drv_d = DRV_A;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_out_q <= '0;
      b_out_q <= '0;
      drv_q   <= DRV_NONE;
    end else begin
      a_out_q <= nxt_a;
      b_out_q <= nxt_b;
      drv_q   <= drv_d;
    end
  end

  assign a_out = a_out_q;
  assign b_out = b_out_q;
  assign a_oe  = {W{drv_q == DRV_A}};
  assign b_oe  = {W{drv_q == DRV_B}};

endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
  import regbus_pkg::*;
#(
  parameter int SLICES  = 2,
  parameter int SLICE_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [SLICES-1:0]           oe_n,
  input  logic [SLICES-1:0]           dir,
  input  logic [SLICES-1:0]           sel_ab,
  input  logic [SLICES-1:0]           sel_ba,
  input  logic [SLICES-1:0]           stclk_a,
  input  logic [SLICES-1:0]           stclk_b,
  input  logic                        pwr_a_ok,
  input  logic                        pwr_b_ok,
  input  logic [SLICES*SLICE_W-1:0]   a_in,
  output logic [SLICES*SLICE_W-1:0]   a_out,
  output logic [SLICES*SLICE_W-1:0]   a_oe,
  input  logic [SLICES*SLICE_W-1:0]   b_in,
  output logic [SLICES*SLICE_W-1:0]   b_out,
  output logic [SLICES*SLICE_W-1:0]   b_oe
);

  localparam int TOTAL_W = SLICES * SLICE_W;

  logic pwr_ok;
  assign pwr_ok = pwr_a_ok & pwr_b_ok;

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    localparam int LO = s * SLICE_W;
    slice_ctrl_t ctrl;

    assign ctrl = '{oe_n:    oe_n[s],
                    dir:     dir[s],
                    sel_ab:  sel_ab[s],
                    sel_ba:  sel_ba[s],
                    stclk_a: stclk_a[s],
                    stclk_b: stclk_b[s]};

    regbus_slice #(.W(SLICE_W)) slice_i (
      .clk    (clk),
      .rst    (rst),
      .ctrl   (ctrl),
      .pwr_ok (pwr_ok),
      .a_in   (a_in[LO +: SLICE_W]),
      .b_in   (b_in[LO +: SLICE_W]),
      .a_out  (a_out[LO +: SLICE_W]),
      .a_oe   (a_oe[LO +: SLICE_W]),
      .b_out  (b_out[LO +: SLICE_W]),
      .b_oe   (b_oe[LO +: SLICE_W])
    );
  end

  if (TOTAL_W < 1) begin : g_bad_width
    initial $display("regbus_xcvr: width must be positive");
  end

endmodule

// File: rtl/regbus_xcvr_chk.sv
module regbus_xcvr_chk #(
  parameter int SLICES  = 2,
  parameter int SLICE_W = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic [SLICES-1:0]         oe_n,
  input logic [SLICES-1:0]         dir,
  input logic [SLICES-1:0]         sel_ab,
  input logic [SLICES-1:0]         sel_ba,
  input logic                      pwr_a_ok,
  input logic                      pwr_b_ok,
  input logic [SLICES*SLICE_W-1:0] a_in,
  input logic [SLICES*SLICE_W-1:0] a_out,
  input logic [SLICES*SLICE_W-1:0] a_oe,
  input logic [SLICES*SLICE_W-1:0] b_in,
  input logic [SLICES*SLICE_W-1:0] b_out,
  input logic [SLICES*SLICE_W-1:0] b_oe
);

  for (genvar s = 0; s < SLICES; s++) begin : g_chk
    localparam int LO = s * SLICE_W;

    // R3
    one_port_driven_chk: assert property (@(posedge clk) disable iff (rst)
      !((|a_oe[LO +: SLICE_W]) && (|b_oe[LO +: SLICE_W])));

    // R2
    isolated_chk: assert property (@(posedge clk) disable iff (rst)
      oe_n[s] |=> (a_oe[LO +: SLICE_W] == '0) && (b_oe[LO +: SLICE_W] == '0));

    // R8
    power_off_chk: assert property (@(posedge clk) disable iff (rst)
      !(pwr_a_ok && pwr_b_ok) |=> (a_oe[LO +: SLICE_W] == '0) && (b_oe[LO +: SLICE_W] == '0));

    // R4
    live_to_b_chk: assert property (@(posedge clk) disable iff (rst)
      (!oe_n[s] && dir[s] && !sel_ab[s] && pwr_a_ok && pwr_b_ok)
      |=> (&b_oe[LO +: SLICE_W]) && (b_out[LO +: SLICE_W] == $past(a_in[LO +: SLICE_W])));

    // R4
    live_to_a_chk: assert property (@(posedge clk) disable iff (rst)
      (!oe_n[s] && !dir[s] && !sel_ba[s] && pwr_a_ok && pwr_b_ok)
      |=> (&a_oe[LO +: SLICE_W]) && (a_out[LO +: SLICE_W] == $past(b_in[LO +: SLICE_W])));
  end

endmodule

bind regbus_xcvr regbus_xcvr_chk #(.SLICES(SLICES), .SLICE_W(SLICE_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .oe_n     (oe_n),
  .dir      (dir),
  .sel_ab   (sel_ab),
  .sel_ba   (sel_ba),
  .pwr_a_ok (pwr_a_ok),
  .pwr_b_ok (pwr_b_ok),
  .a_in     (a_in),
  .a_out    (a_out),
  .a_oe     (a_oe),
  .b_in     (b_in),
  .b_out    (b_out),
  .b_oe     (b_oe)
);

// File: tb/regbus_xcvr_tb.sv
module regbus_xcvr_tb_top;

  localparam int SL = 2;
  localparam int SW = 8;
  localparam int W  = SL * SW;

  logic          clk = 1'b0;
  logic          rst;
  logic [SL-1:0] oe_n, dir, sel_ab, sel_ba, stclk_a, stclk_b;
  logic          pwr_a_ok, pwr_b_ok;
  logic [W-1:0]  a_in, b_in;
  logic [W-1:0]  a_out, a_oe, b_out, b_oe;

  always #10 clk = ~clk;

  regbus_xcvr #(.SLICES(SL), .SLICE_W(SW)) dut_i (
    .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir), .sel_ab(sel_ab),
    .sel_ba(sel_ba), .stclk_a(stclk_a), .stclk_b(stclk_b),
    .pwr_a_ok(pwr_a_ok), .pwr_b_ok(pwr_b_ok), .a_in(a_in), .a_out(a_out),
    .a_oe(a_oe), .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  int checks = 0;
  int errors = 0;
  string cur_req = "R11";
  bit done = 0;

  // behavioural reference state
  int ra [SL];
  int rb [SL];
  bit pca [SL];
  bit pcb [SL];
  int eao [SL];
  int ebo [SL];
  bit eaoe [SL];
  bit eboe [SL];

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_step();
    for (int s = 0; s < SL; s++) begin
      int ain = int'(a_in[s*SW +: SW]);
      int bin = int'(b_in[s*SW +: SW]);
      if (rst) begin
        ra[s] = 0; rb[s] = 0; pca[s] = 0; pcb[s] = 0;
        eao[s] = 0; ebo[s] = 0; eaoe[s] = 0; eboe[s] = 0;
      end else begin
        int resa = eaoe[s] ? eao[s] : ain;
        int resb = eboe[s] ? ebo[s] : bin;
        int na = (stclk_a[s] && !pca[s]) ? resa : ra[s];
        int nb = (stclk_b[s] && !pcb[s]) ? resb : rb[s];
        bit en = !oe_n[s] && pwr_a_ok && pwr_b_ok;
        eao[s]  = sel_ba[s] ? rb[s] : bin;
        ebo[s]  = sel_ab[s] ? ra[s] : ain;
        eaoe[s] = en && !dir[s];
        eboe[s] = en && dir[s];
        ra[s] = na; rb[s] = nb;
        pca[s] = stclk_a[s]; pcb[s] = stclk_b[s];
      end
    end
  endtask

  task automatic compare();
    for (int s = 0; s < SL; s++) begin
      chk(cur_req, "a_out", int'(a_out[s*SW +: SW]), eao[s]);
      chk(cur_req, "b_out", int'(b_out[s*SW +: SW]), ebo[s]);
      chk(cur_req, "a_oe",  int'(a_oe[s*SW +: SW]),  eaoe[s] ? 255 : 0);
      chk(cur_req, "b_oe",  int'(b_oe[s*SW +: SW]),  eboe[s] ? 255 : 0);
      // R3: both ports of one slice enabled together is always wrong
      chk("R3", "both_oe", int'((|a_oe[s*SW +: SW]) && (|b_oe[s*SW +: SW])), 0);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      model_step();
      @(negedge clk);
      compare();
    end
  endtask

  task automatic set_all(bit o, bit d, bit sab, bit sba, bit ca, bit cb);
    oe_n = {SL{o}}; dir = {SL{d}}; sel_ab = {SL{sab}}; sel_ba = {SL{sba}};
    stclk_a = {SL{ca}}; stclk_b = {SL{cb}};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; pwr_a_ok = 1'b1; pwr_b_ok = 1'b1;
    set_all(0, 0, 0, 0, 0, 0);
    a_in = 16'h1234; b_in = 16'hABCD;
    @(negedge clk);
    // R11 reset clears outputs and enables
    cur_req = "R11"; tick(2);
    rst = 1'b0;

    // R4 live data each way
    cur_req = "R4";
    set_all(0, 0, 0, 0, 0, 0); b_in = 16'h5AC3; tick(2);
    b_in = 16'h0F0F; tick(1);
    set_all(0, 1, 0, 0, 0, 0); a_in = 16'h7E81; tick(2);

    // R3 direction flip every cycle
    cur_req = "R3";
    for (int i = 0; i < 6; i++) begin
      dir = {SL{i[0]}}; a_in = 16'h1111 * i; b_in = 16'hF0F0 ^ i; tick(1);
    end

    // R2 isolation with every direction
    cur_req = "R2";
    set_all(1, 0, 0, 0, 0, 0); tick(2);
    set_all(1, 1, 1, 1, 0, 0); tick(2);

    // R6 captures while isolated, single and simultaneous
    cur_req = "R6";
    set_all(1, 0, 0, 0, 0, 0); a_in = 16'hA55A; b_in = 16'h3CC3; tick(1);
    stclk_a = '1; tick(1);
    stclk_a = '0; a_in = 16'h6996; b_in = 16'hC33C; tick(1);
    stclk_a = '1; stclk_b = '1; tick(1);
    stclk_a = '0; stclk_b = '0; tick(1);

    // R7 hold without strobe edges, then recall
    cur_req = "R7";
    stclk_a = '1; a_in = 16'hDEAD; b_in = 16'hBEEF; tick(5);
    stclk_a = '0; tick(1);
    cur_req = "R5";
    set_all(0, 0, 0, 1, 0, 0); tick(2);
    set_all(0, 1, 1, 0, 0, 0); tick(2);

    // R9 select toggles between distinct live and stored values
    cur_req = "R9";
    a_in = 16'h0102;
    for (int i = 0; i < 6; i++) begin sel_ab = {SL{i[0]}}; tick(1); end
    dir = '0;
    for (int i = 0; i < 6; i++) begin sel_ba = {SL{i[0]}}; b_in = 16'h7788 + i; tick(1); end

    // R8 each supply off in turn
    cur_req = "R8";
    set_all(0, 1, 0, 0, 0, 0); pwr_a_ok = 1'b0; tick(3);
    pwr_a_ok = 1'b1; tick(1);
    dir = '0; pwr_b_ok = 1'b0; tick(3);
    pwr_b_ok = 1'b1; tick(1);

    // R10 capture of a port the block drives: junk on the input pin
    cur_req = "R10";
    set_all(0, 0, 0, 1, 0, 0); a_in = 16'hEEEE; tick(2);
    stclk_a = '1; tick(1);
    stclk_a = '0; set_all(0, 1, 1, 0, 0, 0); tick(2);

    // R1 slices with opposite settings, then random traffic
    cur_req = "R1";
    oe_n = 2'b00; dir = 2'b10; sel_ab = 2'b01; sel_ba = 2'b10;
    stclk_a = 2'b01; stclk_b = 2'b10; a_in = 16'h4321; b_in = 16'h8765; tick(3);
    oe_n = 2'b01; tick(2);
    for (int i = 0; i < 3000; i++) begin
      oe_n = SL'($urandom); dir = SL'($urandom); sel_ab = SL'($urandom);
      sel_ba = SL'($urandom); stclk_a = SL'($urandom); stclk_b = SL'($urandom);
      pwr_a_ok = ($urandom % 8) != 0; pwr_b_ok = ($urandom % 8) != 0;
      a_in = W'($urandom); b_in = W'($urandom);
      tick(1);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule